// File: doc/BRIEF.md
# Partition Link Power-State Coordinator

This block ties the active-state link power decisions of one switch partition together. The partition has one upstream port and up to `NUM_DS` downstream ports. Each port's membership bit says whether it belongs to the partition, and these bits may change while the block runs. Each port also reports three levels: whether its receiver is in the low-latency standby state L0s, whether its transmitter is in L0s, and whether its link is in L1 or a deeper state.

From these levels the block drives permissions and requests back to the ports. For the upstream port it drives L0s entry permission, an L0s exit request, L1 entry permission and an L1 exit request. For each downstream port it drives L0s entry permission, an L0s exit request and an L1 exit request. A wake seen on the receive side of one side of the partition becomes an exit request on the transmit side of the other side. When a port joins the partition, the block evaluates it again against the ports already in the partition.

Each port has a two-state membership machine. `PORT_OUT` moves to `PORT_IN` on the transition *admit*, taken when the membership bit is sampled high. `PORT_IN` moves back to `PORT_OUT` on the transition *evict*, taken when the bit is sampled low. Both states hold otherwise. A port is *joining* in the one cycle where its machine is in `PORT_OUT` and its membership bit is high. Every output is registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `aspm_partition_coord`

## Requirements
- R1: A port joins when its membership bit is sampled 1 while its machine is in `PORT_OUT`, which is the case after reset or after the bit was sampled 0. An exit request caused by a join appears in the cycle after that sample and lasts one cycle.
- R2: When a member downstream receiver that is not joining goes from L0s (1) to L0 (0), `us_l0s_exit_req` pulses.
- R3: When the upstream receiver goes from L0s to L0 and the upstream port is a member and not joining, `ds_l0s_exit_req` pulses on every member downstream port.
- R4: `us_l0s_entry_ok` is 1 only when the upstream port is a member, at least one downstream port is a member, and every member downstream receiver is in L0s.
- R5: `ds_l0s_entry_ok[i]` is 1 when port i and the upstream port are members and the upstream receiver is in L0s.
- R6: A downstream port that joins with its receiver in L0 while the upstream transmitter is in L0s raises `us_l0s_exit_req`.
- R7: A downstream port that joins with its transmitter in L0s while the upstream receiver is in L0 raises its own `ds_l0s_exit_req`.
- R8: An upstream port that joins with its receiver in L0 raises `ds_l0s_exit_req` on every member downstream port whose transmitter is in L0s. If it joins with its transmitter in L0s while any member downstream receiver is in L0, it raises `us_l0s_exit_req`. If it joins with its receiver in L0s, L0s entry is permitted on member downstream ports.
- R9: `us_l1_entry_ok` is 1 only when the upstream port is a member and every member downstream link is in L1 (1). With no member downstream ports it stays 0.
- R10: A downstream port that joins in L0 (link level 0) while the upstream link is in L1 raises `us_l1_exit_req`.
- R11: A downstream port that joins in L1 while the upstream link is in L0 raises its own `ds_l1_exit_req`.
- R12: Downstream ports whose membership bit is clear are ignored and their outputs stay 0. While the upstream port is not a member, every output is 0.
- R13: For a given port, an exit request and the L0s or L1 entry permission of the same kind are never 1 in the same cycle.
- R14: Synchronous reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_member | input | 1 | Upstream port belongs to the partition |
| ds_member | input | NUM_DS | Per downstream port membership |
| us_rx_l0s | input | 1 | Upstream receiver in L0s (1) or L0 (0) |
| us_tx_l0s | input | 1 | Upstream transmitter in L0s (1) or L0 (0) |
| us_in_l1 | input | 1 | Upstream link in L1 or deeper (1) |
| ds_rx_l0s | input | NUM_DS | Downstream receivers in L0s |
| ds_tx_l0s | input | NUM_DS | Downstream transmitters in L0s |
| ds_in_l1 | input | NUM_DS | Downstream links in L1 or deeper |
| us_l0s_entry_ok | output | 1 | Upstream transmitter may enter L0s |
| us_l0s_exit_req | output | 1 | Upstream transmitter must leave L0s |
| us_l1_entry_ok | output | 1 | Upstream port may start L1 entry |
| us_l1_exit_req | output | 1 | Upstream port must leave L1 |
| ds_l0s_entry_ok | output | NUM_DS | Downstream transmitter may enter L0s |
| ds_l0s_exit_req | output | NUM_DS | Downstream transmitter must leave L0s |
| ds_l1_exit_req | output | NUM_DS | Downstream port must leave L1 |

## Verification
The assertions assume that every input is a synchronous level which is stable around the rising edge. Receiver wakes are taken as falling edges between two consecutive samples, and a join is a membership bit seen high while the port's machine is out of the partition. The stimulus changes inputs only on the falling clock edge and holds each set of values for exactly one cycle. Status levels on ports outside the partition are changed freely, so the bench can show that they are ignored.

// File: rtl/apc_pkg.sv
package apc_pkg;
    typedef enum logic {
        PORT_OUT = 1'b0,
        PORT_IN  = 1'b1
    } member_state_e;
endpackage

// File: rtl/apc_member_fsm.sv
module apc_member_fsm
    import apc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic member_i,
    output logic joining_o
);
    member_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PORT_OUT;
        else     state_q <= state_d;
    end

    // next state: admit / evict
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_OUT: if (member_i)  state_d = PORT_IN;
            PORT_IN:  if (!member_i) state_d = PORT_OUT;
            default:  state_d = PORT_OUT;
        endcase
    end

    // outputs
    always_comb begin
        joining_o = (state_q == PORT_OUT) && member_i;
    end

    assert_in_needs_member_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == PORT_IN) |-> $past(member_i));
endmodule

// File: rtl/apc_ds_lane.sv
module apc_ds_lane (
    input  logic clk,
    input  logic rst,
    input  logic member_i,
    input  logic joining_i,
    input  logic rx_l0s_i,
    input  logic tx_l0s_i,
    input  logic l1_i,
    input  logic us_member_i,
    input  logic us_rx_l0s_i,
    input  logic us_rx_wake_i,
    input  logic us_joining_i,
    input  logic us_l1_i,
    output logic rx_wake_o,
    output logic l0s_entry_ok_o,
    output logic l0s_exit_o,
    output logic l1_exit_o
);
    logic rx_q;
    logic exit_d, entry_d, l1x_d;

    always_ff @(posedge clk) begin
        if (rst) rx_q <= 1'b0;
        else     rx_q <= rx_l0s_i;
    end

    // receiver wake seen on an established member
    assign rx_wake_o = member_i && !joining_i && rx_q && !rx_l0s_i;

    always_comb begin
        exit_d  = member_i && us_member_i &&
                  (us_rx_wake_i ||
                   (!us_rx_l0s_i && tx_l0s_i && (joining_i || us_joining_i)));
        entry_d = member_i && us_member_i && us_rx_l0s_i && !exit_d;
        l1x_d   = us_member_i && joining_i && l1_i && !us_l1_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l0s_entry_ok_o <= 1'b0;
            l0s_exit_o     <= 1'b0;
            l1_exit_o      <= 1'b0;
        end else begin
            l0s_entry_ok_o <= entry_d;
            l0s_exit_o     <= exit_d;
            l1_exit_o      <= l1x_d;
        end
    end

    assert_nonmember_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(member_i) |-> !(l0s_entry_ok_o || l0s_exit_o || l1_exit_o));
    assert_l1_exit_on_join_R11: assert property (@(posedge clk) disable iff (rst)
        l1_exit_o |-> $past(joining_i && l1_i && !us_l1_i));
    assert_us_wake_fanout_R3: assert property (@(posedge clk) disable iff (rst)
        $past(us_rx_wake_i && member_i && us_member_i) |-> l0s_exit_o);
    assert_ds_exit_beats_entry_R13: assert property (@(posedge clk) disable iff (rst)
        !(l0s_exit_o && l0s_entry_ok_o));
endmodule

// File: rtl/apc_us_ctrl.sv
module apc_us_ctrl #(
    parameter int NUM_DS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              member_i,
    input  logic              joining_i,
    input  logic              rx_l0s_i,
    input  logic              tx_l0s_i,
    input  logic              l1_i,
    input  logic [NUM_DS-1:0] ds_member_i,
    input  logic [NUM_DS-1:0] ds_joining_i,
    input  logic [NUM_DS-1:0] ds_rx_l0s_i,
    input  logic [NUM_DS-1:0] ds_l1_i,
    input  logic [NUM_DS-1:0] ds_rx_wake_i,
    output logic              rx_wake_o,
    output logic              l0s_entry_ok_o,
    output logic              l0s_exit_o,
    output logic              l1_entry_ok_o,
    output logic              l1_exit_o
);
    logic rx_q;
    logic any_member, all_rx_l0s, all_l1;
    logic join_rx_l0, join_link_l0, member_rx_l0;
    logic exit_d, entry_d, l1x_d, l1e_d;

    always_ff @(posedge clk) begin
        if (rst) rx_q <= 1'b0;
        else     rx_q <= rx_l0s_i;
    end

    assign rx_wake_o = member_i && !joining_i && rx_q && !rx_l0s_i;

    always_comb begin
        any_member   = |ds_member_i;
        all_rx_l0s   = &(~ds_member_i | ds_rx_l0s_i);
        all_l1       = &(~ds_member_i | ds_l1_i);
        join_rx_l0   = |(ds_joining_i & ~ds_rx_l0s_i);
        join_link_l0 = |(ds_joining_i & ~ds_l1_i);
        member_rx_l0 = |(ds_member_i & ~ds_rx_l0s_i);

        exit_d  = member_i && ((|ds_rx_wake_i) ||
                               (tx_l0s_i && join_rx_l0) ||
                               (joining_i && tx_l0s_i && member_rx_l0));
        entry_d = member_i && any_member && all_rx_l0s && !exit_d;
        l1x_d   = member_i && l1_i && join_link_l0;
        l1e_d   = member_i && any_member && all_l1 && !l1x_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l0s_entry_ok_o <= 1'b0;
            l0s_exit_o     <= 1'b0;
            l1_entry_ok_o  <= 1'b0;
            l1_exit_o      <= 1'b0;
        end else begin
            l0s_entry_ok_o <= entry_d;
            l0s_exit_o     <= exit_d;
            l1_entry_ok_o  <= l1e_d;
            l1_exit_o      <= l1x_d;
        end
    end

    assert_l1_entry_all_R9: assert property (@(posedge clk) disable iff (rst)
        l1_entry_ok_o |-> $past(member_i && (|ds_member_i) && (&(~ds_member_i | ds_l1_i))));
    assert_l0s_entry_all_R4: assert property (@(posedge clk) disable iff (rst)
        l0s_entry_ok_o |-> $past(member_i && (&(~ds_member_i | ds_rx_l0s_i))));
    assert_us_exit_beats_entry_R13: assert property (@(posedge clk) disable iff (rst)
        !(l0s_exit_o && l0s_entry_ok_o) && !(l1_exit_o && l1_entry_ok_o));
    assert_wake_to_us_exit_R2: assert property (@(posedge clk) disable iff (rst)
        $past(member_i && (|ds_rx_wake_i)) |-> l0s_exit_o);
endmodule

// File: rtl/aspm_partition_coord.sv
module aspm_partition_coord #(
    parameter int NUM_DS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_member,
    input  logic [NUM_DS-1:0] ds_member,
    input  logic              us_rx_l0s,
    input  logic              us_tx_l0s,
    input  logic              us_in_l1,
    input  logic [NUM_DS-1:0] ds_rx_l0s,
    input  logic [NUM_DS-1:0] ds_tx_l0s,
    input  logic [NUM_DS-1:0] ds_in_l1,
    output logic              us_l0s_entry_ok,
    output logic              us_l0s_exit_req,
    output logic              us_l1_entry_ok,
    output logic              us_l1_exit_req,
    output logic [NUM_DS-1:0] ds_l0s_entry_ok,
    output logic [NUM_DS-1:0] ds_l0s_exit_req,
    output logic [NUM_DS-1:0] ds_l1_exit_req
);
    localparam int LANES = NUM_DS;

    logic             us_joining;
    logic             us_rx_wake;
    logic [LANES-1:0] ds_joining;
    logic [LANES-1:0] ds_rx_wake;

    apc_member_fsm u_us_fsm (
        .clk       (clk),
        .rst       (rst),
        .member_i  (us_member),
        .joining_o (us_joining)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        apc_member_fsm u_fsm (
            .clk       (clk),
            .rst       (rst),
            .member_i  (ds_member[g]),
            .joining_o (ds_joining[g])
        );

        apc_ds_lane u_lane (
            .clk            (clk),
            .rst            (rst),
            .member_i       (ds_member[g]),
            .joining_i      (ds_joining[g]),
            .rx_l0s_i       (ds_rx_l0s[g]),
            .tx_l0s_i       (ds_tx_l0s[g]),
            .l1_i           (ds_in_l1[g]),
            .us_member_i    (us_member),
            .us_rx_l0s_i    (us_rx_l0s),
            .us_rx_wake_i   (us_rx_wake),
            .us_joining_i   (us_joining),
            .us_l1_i        (us_in_l1),
            .rx_wake_o      (ds_rx_wake[g]),
            .l0s_entry_ok_o (ds_l0s_entry_ok[g]),
            .l0s_exit_o     (ds_l0s_exit_req[g]),
            .l1_exit_o      (ds_l1_exit_req[g])
        );
    end

    apc_us_ctrl #(.NUM_DS(LANES)) u_us (
        .clk            (clk),
        .rst            (rst),
        .member_i       (us_member),
        .joining_i      (us_joining),
        .rx_l0s_i       (us_rx_l0s),
        .tx_l0s_i       (us_tx_l0s),
        .l1_i           (us_in_l1),
        .ds_member_i    (ds_member),
        .ds_joining_i   (ds_joining),
        .ds_rx_l0s_i    (ds_rx_l0s),
        .ds_l1_i        (ds_in_l1),
        .ds_rx_wake_i   (ds_rx_wake),
        .rx_wake_o      (us_rx_wake),
        .l0s_entry_ok_o (us_l0s_entry_ok),
        .l0s_exit_o     (us_l0s_exit_req),
        .l1_entry_ok_o  (us_l1_entry_ok),
        .l1_exit_o      (us_l1_exit_req)
    );

    assert_no_us_member_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(us_member) |-> !(us_l0s_entry_ok || us_l0s_exit_req || us_l1_entry_ok ||
                                us_l1_exit_req || (|ds_l0s_entry_ok) ||
                                (|ds_l0s_exit_req) || (|ds_l1_exit_req)));
endmodule

// File: tb/aspm_partition_coord_tb.sv
module aspm_partition_coord_tb_top;
    localparam int NDS   = 4;
    localparam int NROWS = 16;

    typedef struct packed {
        logic       us_m;
        logic [3:0] ds_m;
        logic [2:0] us_st;   // {rx_l0s, tx_l0s, in_l1}
        logic [3:0] ds_rx;
        logic [3:0] ds_tx;
        logic [3:0] ds_l1;
        logic [3:0] e_us;    // {l0s_ok, l0s_exit, l1_ok, l1_exit}
        logic [3:0] e_dok;
        logic [3:0] e_dex;
        logic [3:0] e_dl1;
        logic [7:0] req_a;
        logic [7:0] req_b;
    } vec_t;

    // each row is held for one cycle; expectation is read one cycle later
    localparam vec_t ROWS [NROWS] = '{
        {1'b0,4'b0000,3'b000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'd12,8'd14}, // R12 R14 idle
        {1'b1,4'b0000,3'b000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'd12,8'd9},  // R9 no ds member
        {1'b1,4'b0011,3'b110,4'b0001,4'b0010,4'b0000,4'b0100,4'b0011,4'b0000,4'b0000,8'd6,8'd5},   // R6 R5 ds join rx L0
        {1'b1,4'b0011,3'b110,4'b0011,4'b0010,4'b0000,4'b1000,4'b0011,4'b0000,4'b0000,8'd4,8'd1},   // R4 R1 pulse gone
        {1'b1,4'b0011,3'b110,4'b0001,4'b0010,4'b0000,4'b0100,4'b0011,4'b0000,4'b0000,8'd2,8'd2},   // R2 ds rx wake
        {1'b1,4'b0011,3'b110,4'b1011,4'b0010,4'b0000,4'b1000,4'b0011,4'b0000,4'b0000,8'd4,8'd4},   // R4
        {1'b1,4'b0011,3'b110,4'b0011,4'b0010,4'b0000,4'b1000,4'b0011,4'b0000,4'b0000,8'd12,8'd2},  // R12 non-member wake
        {1'b1,4'b0011,3'b010,4'b0011,4'b0010,4'b0000,4'b1000,4'b0000,4'b0011,4'b0000,8'd3,8'd5},   // R3 us rx wake
        {1'b1,4'b0011,3'b010,4'b0011,4'b0010,4'b0011,4'b1010,4'b0000,4'b0000,4'b0000,8'd9,8'd12},  // R9 all member L1
        {1'b1,4'b0011,3'b010,4'b0011,4'b0010,4'b0001,4'b1000,4'b0000,4'b0000,4'b0000,8'd9,8'd9},   // R9 one not L1
        {1'b1,4'b0111,3'b001,4'b0011,4'b0010,4'b0011,4'b0001,4'b0000,4'b0000,4'b0000,8'd10,8'd1},  // R10 join L0 vs us L1
        {1'b1,4'b1111,3'b000,4'b0011,4'b1010,4'b1011,4'b0000,4'b0000,4'b1000,4'b1000,8'd11,8'd7},  // R11 R7 join in L1, tx L0s
        {1'b0,4'b1111,3'b000,4'b0011,4'b1010,4'b1011,4'b0000,4'b0000,4'b0000,4'b0000,8'd12,8'd12}, // R12 us not member
        {1'b1,4'b1111,3'b010,4'b0111,4'b0101,4'b0000,4'b0100,4'b0000,4'b0101,4'b0000,8'd8,8'd1},   // R8 us join rx L0
        {1'b0,4'b1111,3'b100,4'b1111,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,4'b0000,8'd12,8'd12}, // R12
        {1'b1,4'b1111,3'b100,4'b1111,4'b0000,4'b0000,4'b1000,4'b1111,4'b0000,4'b0000,8'd8,8'd5}    // R8 R5 us join rx L0s
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           us_member = 1'b0;
    logic [NDS-1:0] ds_member = '0;
    logic           us_rx_l0s = 1'b0, us_tx_l0s = 1'b0, us_in_l1 = 1'b0;
    logic [NDS-1:0] ds_rx_l0s = '0, ds_tx_l0s = '0, ds_in_l1 = '0;
    logic           us_l0s_entry_ok, us_l0s_exit_req, us_l1_entry_ok, us_l1_exit_req;
    logic [NDS-1:0] ds_l0s_entry_ok, ds_l0s_exit_req, ds_l1_exit_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    aspm_partition_coord #(.NUM_DS(NDS)) dut_i (
        .clk(clk), .rst(rst),
        .us_member(us_member), .ds_member(ds_member),
        .us_rx_l0s(us_rx_l0s), .us_tx_l0s(us_tx_l0s), .us_in_l1(us_in_l1),
        .ds_rx_l0s(ds_rx_l0s), .ds_tx_l0s(ds_tx_l0s), .ds_in_l1(ds_in_l1),
        .us_l0s_entry_ok(us_l0s_entry_ok), .us_l0s_exit_req(us_l0s_exit_req),
        .us_l1_entry_ok(us_l1_entry_ok), .us_l1_exit_req(us_l1_exit_req),
        .ds_l0s_entry_ok(ds_l0s_entry_ok), .ds_l0s_exit_req(ds_l0s_exit_req),
        .ds_l1_exit_req(ds_l1_exit_req)
    );

    function automatic logic [15:0] observed();
        return {us_l0s_entry_ok, us_l0s_exit_req, us_l1_entry_ok, us_l1_exit_req,
                ds_l0s_entry_ok, ds_l0s_exit_req, ds_l1_exit_req};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        us_member = v.us_m;
        ds_member = v.ds_m;
        {us_rx_l0s, us_tx_l0s, us_in_l1} = v.us_st;
        ds_rx_l0s = v.ds_rx;
        ds_tx_l0s = v.ds_tx;
        ds_in_l1  = v.ds_l1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R14 reset state", observed(), 16'h0000);
        rst = 1'b0;

        for (int r = 0; r < NROWS; r++) begin
            apply(ROWS[r]);
            @(negedge clk);
            check($sformatf("R%0d/R%0d row %0d", ROWS[r].req_a, ROWS[r].req_b, r),
                  observed(), {ROWS[r].e_us, ROWS[r].e_dok, ROWS[r].e_dex, ROWS[r].e_dl1});
        end

        // R2 R13: wake on ds0 gives exit, entry withdrawn
        ds_rx_l0s = 4'b1110;
        @(negedge clk);
        check("R2 R13 wake exit, entry off", observed(), {4'b0100, 4'b1111, 4'b0000, 4'b0000});
        // R1: exit lasts one cycle while inputs hold
        @(negedge clk);
        check("R1 exit pulse ends", observed(), {4'b0000, 4'b1111, 4'b0000, 4'b0000});
        // back to all receivers in L0s
        ds_rx_l0s = 4'b1111;
        @(negedge clk);
        check("R4 entry restored", observed(), {4'b1000, 4'b1111, 4'b0000, 4'b0000});
        // R14: synchronous reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R14 mid-run reset", observed(), 16'h0000);
        rst = 1'b0;

        finish_run();
    end
endmodule